// File: doc/BRIEF.md
# Trap Value Capture Register

This block holds the machine-level trap value register, XLEN bits wide and reached by software at CSR number 0x343. When the core takes a synchronous exception, the register records whichever value helps the trap handler most. For breakpoints and for misaligned or access faults on fetch, load and store, it records the faulting address. For an illegal instruction, it records the instruction bits themselves, which spares an emulation handler from fetching the instruction again. Build-time options can turn instruction capture off, and then an illegal-instruction trap writes zero.

Each cycle, one of four named sources selects the next register value. SRC_KEEP holds the current value. SRC_ADDR loads the fault address. SRC_INSN loads the shaped instruction bits. SRC_SOFT loads the software write data. The source moves from SRC_KEEP to SRC_ADDR or SRC_INSN when a capturing trap strobe arrives. It moves to SRC_SOFT when software writes the register and no capturing trap is present in the same cycle. It returns to SRC_KEEP in every other case. The instruction length comes from the two low bits of the buffered instruction. The upstream fetch logic supplies the fault address. For a fetch fault on a variable-length instruction, that address points at the faulting part of the instruction, and the block stores it unchanged.

Top module: `tval_capture`

## Requirements
- R1: While rst_n is low the register reads zero, even if a trap strobe is present, and it is still zero in the first cycle after reset.
- R2: A trap with trap_irq low and exception code 0, 1, 3, 4, 5, 6 or 7 loads fault_addr (its low XLEN bits). The new value is visible on tval in the cycle after the strobe.
- R3: With instruction capture on, a trap with code 2 loads the instruction. If insn_buf[1:0] is 2'b11, the instruction is 32 bits long and is stored whole. Otherwise it is 16 bits long: bits [15:0] are stored and all higher register bits are cleared.
- R4: If the instruction is longer than XLEN, only its first XLEN bits are stored (bits [XLEN-1:0]).
- R5: With instruction capture off (CAPTURE_INSN = 0), a trap with code 2 writes zero.
- R6: The register keeps its value after a trap strobe with trap_irq high, after a strobe with a code of 8 or above, and in any cycle with neither a capturing trap nor a software write.
- R7: A software write (csr_we high with csr_addr = 0x343) loads csr_wdata. A write to any other address leaves the register unchanged. csr_rdata shows the register when csr_addr = 0x343 and zero for any other address.
- R8: If a capturing trap (R2, R3 or R5) and a software write occur in the same cycle, the trap value is stored. If the trap in that cycle does not capture, the software write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Trap strobe, one cycle per trap |
| trap_irq | input | 1 | The trap is an interrupt |
| trap_code | input | CODE_W | Exception code |
| fault_addr | input | XLEN | Faulting address |
| insn_buf | input | IBUF_W | Fetched bits of the faulting instruction, first parcel in the low bits |
| csr_addr | input | 12 | Software CSR address |
| csr_we | input | 1 | Software write enable |
| csr_wdata | input | XLEN | Software write data |
| csr_rdata | output | XLEN | Read data, zero when the address does not match |
| tval | output | XLEN | Current register value |

## Verification
A wrong source choice appears on tval in the cycle right after the strobe. Examples are a misdecoded exception code, an interrupt that updates the register, or a software write that beats a trap. The value then stays wrong until the next capture or write, so every comparison that follows exposes it. A wrong length decision or wrong width shaping appears in the upper bits of tval after an illegal-instruction trap. These errors are checked on a full-width build, a narrow build and a build with capture turned off, all driven with the same stimulus.

// File: rtl/tval_pkg.sv
package tval_pkg;
    localparam logic [11:0] TVAL_CSR_NUM = 12'h343;

    typedef enum logic [1:0] {
        CAP_HOLD,
        CAP_ADDR,
        CAP_INSN
    } cap_kind_e;

    typedef enum logic [1:0] {
        SRC_KEEP,
        SRC_ADDR,
        SRC_INSN,
        SRC_SOFT
    } src_e;
endpackage

// File: rtl/tval_cause_decode.sv
module tval_cause_decode
    import tval_pkg::*;
#(
    parameter int unsigned CODE_W = 4
) (
    input  logic              irq,
    input  logic [CODE_W-1:0] code,
    output cap_kind_e         kind
);
    always_comb begin
        kind = CAP_HOLD;
        if (!irq) begin
            unique case (int'(code))
                0, 1, 3, 4, 5, 6, 7: kind = CAP_ADDR;
                2:                   kind = CAP_INSN;
                default:             kind = CAP_HOLD;
            endcase
        end
    end
endmodule

// File: rtl/tval_insn_format.sv
module tval_insn_format #(
    parameter int unsigned XLEN         = 32,
    parameter int unsigned IBUF_W       = 32,
    parameter bit          CAPTURE_INSN = 1'b1
) (
    input  logic [IBUF_W-1:0] insn,
    output logic [XLEN-1:0]   value
);
    localparam int unsigned HALF_W = 16;

    logic              is_short;
    logic [IBUF_W-1:0] shaped;
    logic [XLEN-1:0]   fitted;

    assign is_short = (insn[1:0] != 2'b11);
    assign shaped   = is_short ? IBUF_W'(insn[HALF_W-1:0]) : insn;

    generate
        if (XLEN >= IBUF_W) begin : g_widen
            assign fitted = XLEN'(shaped);
        end else begin : g_trunc
            assign fitted = shaped[XLEN-1:0];
        end
    endgenerate

    assign value = (CAPTURE_INSN != 1'b0) ? fitted : '0;
endmodule

// File: rtl/tval_capture.sv
module tval_capture
    import tval_pkg::*;
#(
    parameter int unsigned XLEN         = 32,
    parameter int unsigned IBUF_W       = 32,
    parameter int unsigned CODE_W       = 4,
    parameter bit          CAPTURE_INSN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_valid,
    input  logic              trap_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [XLEN-1:0]   fault_addr,
    input  logic [IBUF_W-1:0] insn_buf,
    input  logic [11:0]       csr_addr,
    input  logic              csr_we,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic [XLEN-1:0]   tval
);
    cap_kind_e       kind;
    src_e            src;
    logic [XLEN-1:0] insn_value;
    logic [XLEN-1:0] tval_d;
    logic [XLEN-1:0] tval_q;
    logic            csr_hit;
    logic            csr_wr;

    tval_cause_decode #(.CODE_W(CODE_W)) u_decode (
        .irq  (trap_irq),
        .code (trap_code),
        .kind (kind)
    );

    tval_insn_format #(
        .XLEN         (XLEN),
        .IBUF_W       (IBUF_W),
        .CAPTURE_INSN (CAPTURE_INSN)
    ) u_format (
        .insn  (insn_buf),
        .value (insn_value)
    );

    assign csr_hit = (csr_addr == TVAL_CSR_NUM);
    assign csr_wr  = csr_we && csr_hit;

    always_comb begin
        src = SRC_KEEP;
        if (trap_valid && kind == CAP_ADDR) begin
            src = SRC_ADDR;
        end else if (trap_valid && kind == CAP_INSN) begin
            src = SRC_INSN;
        end else if (csr_wr) begin
            src = SRC_SOFT;
        end
    end

    always_comb begin
        unique case (src)
            SRC_ADDR: tval_d = fault_addr;
            SRC_INSN: tval_d = insn_value;
            SRC_SOFT: tval_d = csr_wdata;
            default:  tval_d = tval_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tval_q <= '0;
        end else begin
            tval_q <= tval_d;
        end
    end

    assign tval      = tval_q;
    assign csr_rdata = csr_hit ? tval_q : '0;

    assert_addr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !trap_irq && (int'(trap_code) <= 7) && (int'(trap_code) != 2))
        |=> (tval == $past(fault_addr)));

    assert_short_insn_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((CAPTURE_INSN != 1'b0) && (XLEN >= 16) && trap_valid && !trap_irq &&
         (int'(trap_code) == 2) && (insn_buf[1:0] != 2'b11))
        |=> (tval == XLEN'($past(insn_buf[15:0]))));

    assert_nocap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((CAPTURE_INSN == 1'b0) && trap_valid && !trap_irq && (int'(trap_code) == 2))
        |=> (tval == '0));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(trap_valid && !trap_irq && (int'(trap_code) <= 7)) &&
         !(csr_we && csr_addr == TVAL_CSR_NUM))
        |=> $stable(tval));

    assert_trap_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !trap_irq && (int'(trap_code) <= 7) && csr_we &&
         csr_addr == TVAL_CSR_NUM)
        |=> (tval == ((int'($past(trap_code)) == 2) ? $past(insn_value) : $past(fault_addr))));
endmodule

// File: tb/tval_capture_bench.sv
`timescale 1ns/1ps
module tval_capture_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_valid = 1'b0;
    logic        trap_irq = 1'b0;
    logic [3:0]  trap_code = '0;
    logic [31:0] fault_addr = '0;
    logic [31:0] insn_buf = '0;
    logic [11:0] csr_addr = '0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] rd32, tv32, rd0, tv0;
    logic [15:0] rd16, tv16;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m32 = '0;
    logic [31:0] m16 = '0;
    logic [31:0] m0  = '0;

    typedef struct {
        logic [31:0] e32;
        logic [31:0] e16;
        logic [31:0] e0;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    tval_capture #(.XLEN(32), .CAPTURE_INSN(1'b1)) u_tval_capture (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_irq(trap_irq),
        .trap_code(trap_code), .fault_addr(fault_addr), .insn_buf(insn_buf),
        .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(rd32), .tval(tv32)
    );

    tval_capture #(.XLEN(16), .CAPTURE_INSN(1'b1)) u_tval_capture_narrow (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_irq(trap_irq),
        .trap_code(trap_code), .fault_addr(fault_addr[15:0]), .insn_buf(insn_buf),
        .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata[15:0]),
        .csr_rdata(rd16), .tval(tv16)
    );

    tval_capture #(.XLEN(32), .CAPTURE_INSN(1'b0)) u_tval_capture_nocap (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_irq(trap_irq),
        .trap_code(trap_code), .fault_addr(fault_addr), .insn_buf(insn_buf),
        .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(rd0), .tval(tv0)
    );

    task automatic check(string tag, string inst, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, inst, act, exp);
        end
    endtask

    function automatic logic [31:0] mnext(logic [31:0] prev, bit cap, bit narrow);
        logic [31:0] r;
        logic [31:0] iv;
        logic [31:0] m;
        m = narrow ? 32'h0000_FFFF : 32'hFFFF_FFFF;
        r = prev;
        if (trap_valid && !trap_irq && trap_code <= 4'd7) begin
            if (trap_code == 4'd2) begin
                iv = (insn_buf[1:0] != 2'b11) ? {16'h0, insn_buf[15:0]} : insn_buf;
                r  = cap ? (iv & m) : 32'h0;
            end else begin
                r = fault_addr & m;
            end
        end else if (csr_we && csr_addr == 12'h343) begin
            r = csr_wdata & m;
        end
        return r;
    endfunction

    task automatic op(string tag, bit tv, bit irq, logic [3:0] code, logic [31:0] addr,
                      logic [31:0] insn, bit we, logic [11:0] caddr, logic [31:0] wd);
        exp_t it;
        bit   hit;
        @(negedge clk);
        trap_valid = tv; trap_irq = irq; trap_code = code; fault_addr = addr;
        insn_buf = insn; csr_we = we; csr_addr = caddr; csr_wdata = wd;
        hit = (caddr == 12'h343);
        #1;
        check("R7 read", "full",   rd32,         hit ? m32 : 32'h0);
        check("R7 read", "narrow", {16'h0, rd16}, hit ? m16 : 32'h0);
        check("R7 read", "nocap",  rd0,          hit ? m0  : 32'h0);
        m32 = mnext(m32, 1'b1, 1'b0);
        m16 = mnext(m16, 1'b1, 1'b1);
        m0  = mnext(m0,  1'b0, 1'b0);
        it.e32 = m32; it.e16 = m16; it.e0 = m0; it.tag = tag;
        sb.push_back(it);
    endtask

    always @(posedge clk) begin
        exp_t it;
        #2;
        if (sb.size() > 0) begin
            it = sb.pop_front();
            check(it.tag, "full",   tv32,          it.e32);
            check(it.tag, "narrow", {16'h0, tv16}, it.e16);
            check(it.tag, "nocap",  tv0,           it.e0);
        end
    end

    initial begin
        // R1: strobe held during reset must not load
        trap_valid = 1'b1; trap_code = 4'd1; fault_addr = 32'hCAFE_0004;
        csr_we = 1'b1; csr_addr = 12'h343; csr_wdata = 32'h1111_2222;
        repeat (3) @(negedge clk);
        #1;
        check("R1", "full",   tv32,          32'h0);
        check("R1", "narrow", {16'h0, tv16}, 32'h0);
        check("R1", "nocap",  tv0,           32'h0);
        trap_valid = 1'b0; csr_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        op("R1 idle", 0, 0, 4'd0, 32'h0, 32'h0, 0, 12'h343, 32'h0);
        // R2: each address-class code
        op("R2 code0", 1, 0, 4'd0, 32'h1000_0002, 32'h0, 0, 12'h343, 32'h0);
        op("R2 code5", 1, 0, 4'd5, 32'hDEAD_BEE0, 32'h0, 0, 12'h343, 32'h0);
        op("R2 code3", 1, 0, 4'd3, 32'h0000_0ABC, 32'h0, 0, 12'h343, 32'h0);
        for (int c = 1; c <= 7; c++) begin
            if (c != 2 && c != 3 && c != 5)
                op("R2 loop", 1, 0, 4'(c), 32'h8000_0001 + 32'(c * 32'h0101_0000), 32'h0, 0, 12'h343, 32'h0);
        end
        // R3/R4/R5: 32-bit instruction (low bits 11)
        op("R3 R4 R5 long", 1, 0, 4'd2, 32'h0, 32'hFEDC_BA93, 0, 12'h343, 32'h0);
        // R6: holds after non-capturing traps
        op("R6 code8", 1, 0, 4'd8, 32'h7777_7777, 32'h0, 0, 12'h343, 32'h0);
        op("R6 irq",   1, 1, 4'd1, 32'h6666_6666, 32'h0, 0, 12'h343, 32'h0);
        op("R6 code15", 1, 0, 4'd15, 32'h5555_5555, 32'h0, 0, 12'h343, 32'h0);
        op("R6 irq illegal", 1, 1, 4'd2, 32'h0, 32'hFFFF_FFFF, 0, 12'h343, 32'h0);
        // R3/R5: 16-bit instruction, upper bits cleared
        op("R2 setup", 1, 0, 4'd4, 32'hFFFF_FFFF, 32'h0, 0, 12'h343, 32'h0);
        op("R3 R5 short", 1, 0, 4'd2, 32'h0, 32'h1234_5678, 0, 12'h343, 32'h0);
        op("R3 short 01", 1, 0, 4'd2, 32'h0, 32'hABCD_0001, 0, 12'h343, 32'h0);
        // R7: software write and ignored write
        op("R7 write", 0, 0, 4'd0, 32'h0, 32'h0, 1, 12'h343, 32'h55AA_33CC);
        op("R7 other addr", 0, 0, 4'd0, 32'h0, 32'h0, 1, 12'h341, 32'h9999_0000);
        op("R7 read other", 0, 0, 4'd0, 32'h0, 32'h0, 0, 12'h342, 32'h0);
        op("R6 idle", 0, 0, 4'd0, 32'h0, 32'h0, 0, 12'h343, 32'h0);
        // R8: collisions
        op("R8 addr wins", 1, 0, 4'd5, 32'h0BAD_F00D, 32'h0, 1, 12'h343, 32'h1234_ABCD);
        op("R8 insn wins", 1, 0, 4'd2, 32'h0, 32'h0000_4003, 1, 12'h343, 32'hAAAA_5555);
        op("R8 write passes", 1, 0, 4'd9, 32'h3333_3333, 32'h0, 1, 12'h343, 32'h0F0F_F0F0);
        op("R8 irq write", 1, 1, 4'd7, 32'h4444_4444, 32'h0, 1, 12'h343, 32'hC3C3_3C3C);
        op("R6 idle end", 0, 0, 4'd0, 32'h0, 32'h0, 0, 12'h343, 32'h0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1600000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule